// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the main control unit of a multicycle load/store processor. Each instruction takes several clock cycles. The sequencer holds a 4-bit state register. From the current state and the 6-bit opcode field of the instruction register it picks the next state. It decodes the datapath control strobes from the current state alone: memory read and write, instruction register load, register file write, ALU operand and operation selects, PC write, and PC source.

The sequence starts with a fetch cycle and a decode cycle, then branches by instruction class:

- Loads and stores pass through an address-compute cycle before the memory access.
- Register-to-register ALU operations get an execute cycle and a writeback cycle.
- Branches and jumps finish in one extra cycle.

Exceptions take a three-state path. An opcode that the decoder does not recognise, or an ALU overflow reported during the ALU writeback cycle, sends control to a PC-save state and then to a handler-vector state. A 2-bit cause code is latched when the PC-save state is entered. A dedicated return opcode reloads the saved PC.

Top module: `mcyc_ctrl`

## Requirements
- R1: An active-low asynchronous reset puts the state at 0 (fetch) and the cause at 0, whatever the state was when reset was applied.
- R2: State 0 is always followed by state 1. In state 0, `mem_read`, `ir_write` and `pc_write` are 1 and `alu_src_a` is 0.
- R3: In state 1 the opcode selects the next state:
  - 100011 (load) and 101011 (store) go to 2.
  - 000000 (register type) and 001111 (load upper immediate) go to 6.
  - 000100 and 000101 (branch equal / not equal) go to 8.
  - 000010 and 000011 (jump, jump-and-link) go to 9.
  - 010000 (return from exception) goes to 12.
- R4: In state 2 the load opcode leads to state 3 and the store opcode to state 5.
- R5: The following transitions hold: 3 goes to 4; 4, 5, 8 and 9 go to 0; 6 goes to 7; 7 goes to 0 when `ovf` is 0.
- R6: `alu_src_a` is 0 in states 0 and 1 and 1 in states 2, 6 and 8. `pc_write` is 1 in states 0, 9, 11 and 12 and 0 in every other state.
- R7: `mem_read` is 1 only in states 0 and 3 and `mem_write` only in state 5. `iord` is 1 in states 3 and 5.
- R8: An opcode outside the R3 list, seen in state 1, leads to state 10, then 11, then 0, and sets the cause to 0 (undefined instruction) from state 10 on.
- R9: With `ovf` at 1 in state 7, `reg_write` is 0 in that cycle, the next state is 10 and the cause becomes 1 (overflow). `ovf` in any other state has no effect: `reg_write` stays 1 in state 4 and state 4 still goes to 0.
- R10: `epc_write` is 1 only in state 10. `pc_src` is 2 in state 9, 3 (handler vector) in state 11 and 4 (saved PC) in state 12. State 12 goes to 0.
- R11: The cause changes only on entry to state 10 and otherwise holds its value across later instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| ovf | input | 1 | ALU overflow flag |
| state | output | 4 | Current state number |
| cause | output | 2 | Latched exception cause code |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load qualified by the branch outcome |
| pc_src | output | 3 | PC source: 0 incremented, 1 ALU result register, 2 jump target, 3 handler vector, 4 saved PC |
| iord | output | 1 | Memory address from the ALU result instead of the PC |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data taken from memory |
| reg_dst | output | 1 | Destination register taken from the rd field |
| reg_write | output | 1 | Register file write strobe |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register |
| alu_src_b | output | 2 | ALU operand B: 0 register, 1 constant 4, 2 immediate, 3 shifted immediate |
| alu_op | output | 2 | ALU operation class: 0 add, 1 subtract, 2 from function field |
| epc_write | output | 1 | Saved-PC register load |

## Verification
Two functions can meet in one cycle. In the ALU writeback cycle, the register write strobe and the overflow diversion compete.

The bench runs a register-type instruction and raises `ovf` only once the state reads 7. It judges three things:
- `reg_write` drops in that same cycle.
- The next cycle shows state 10 with cause 1.
- The following states are 11 and then 0.

The complementary case is a load with `ovf` held high throughout. There, the bench expects the load writeback cycle to keep its register write and to return to fetch, with the earlier cause left intact.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int OPC_W = 6;
    localparam int ST_W  = 4;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_LOAD    = 4'd3,
        ST_LDWB    = 4'd4,
        ST_STORE   = 4'd5,
        ST_EXEC    = 4'd6,
        ST_ALUWB   = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9,
        ST_SAVE    = 4'd10,
        ST_VECTOR  = 4'd11,
        ST_RESUME  = 4'd12
    } state_e;

    typedef enum logic [2:0] {
        PCS_INC    = 3'd0,
        PCS_ALUOUT = 3'd1,
        PCS_JUMP   = 3'd2,
        PCS_VECTOR = 3'd3,
        PCS_EPC    = 3'd4
    } pcsrc_e;

    typedef enum logic [2:0] {
        CL_MEM,
        CL_ALU,
        CL_BRANCH,
        CL_JUMP,
        CL_RETURN,
        CL_UNDEF
    } opclass_e;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_J     = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_JAL   = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'b001111;
    localparam logic [OPC_W-1:0] OPC_ERET  = 6'b010000;

    typedef struct packed {
        logic       pc_write;
        logic       pc_write_cond;
        pcsrc_e     pc_src;
        logic       iord;
        logic       mem_read;
        logic       mem_write;
        logic       ir_write;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       reg_write;
        logic       alu_src_a;
        logic [1:0] alu_src_b;
        logic [1:0] alu_op;
        logic       epc_write;
    } ctrl_t;

endpackage

// File: rtl/mcyc_opclass.sv
module mcyc_opclass
    import mcyc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output opclass_e         op_class,
    output logic             is_store
);

    always_comb begin
        op_class = CL_UNDEF;
        case (opcode)
            OPC_LW, OPC_SW:     op_class = CL_MEM;
            OPC_RTYPE, OPC_LUI: op_class = CL_ALU;
            OPC_BEQ, OPC_BNE:   op_class = CL_BRANCH;
            OPC_J, OPC_JAL:     op_class = CL_JUMP;
            OPC_ERET:           op_class = CL_RETURN;
            default:            op_class = CL_UNDEF;
        endcase
    end

    assign is_store = (opcode == OPC_SW);

endmodule

// File: rtl/mcyc_strobe_dec.sv
module mcyc_strobe_dec
    import mcyc_pkg::*;
(
    input  state_e state,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        case (state)
            ST_FETCH: begin
                ctrl.mem_read  = 1'b1;
                ctrl.ir_write  = 1'b1;
                ctrl.pc_write  = 1'b1;
                ctrl.pc_src    = PCS_INC;
                ctrl.alu_src_a = 1'b0;
                ctrl.alu_src_b = 2'd1;
                ctrl.alu_op    = 2'd0;
            end
            ST_DECODE: begin
                ctrl.alu_src_a = 1'b0;
                ctrl.alu_src_b = 2'd3;
                ctrl.alu_op    = 2'd0;
            end
            ST_ADDR: begin
                ctrl.alu_src_a = 1'b1;
                ctrl.alu_src_b = 2'd2;
                ctrl.alu_op    = 2'd0;
            end
            ST_LOAD: begin
                ctrl.mem_read = 1'b1;
                ctrl.iord     = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_write  = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_dst    = 1'b0;
            end
            ST_STORE: begin
                ctrl.mem_write = 1'b1;
                ctrl.iord      = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_src_a = 1'b1;
                ctrl.alu_src_b = 2'd0;
                ctrl.alu_op    = 2'd2;
            end
            ST_ALUWB: begin
                ctrl.reg_write  = 1'b1;
                ctrl.reg_dst    = 1'b1;
                ctrl.mem_to_reg = 1'b0;
            end
            ST_BRANCH: begin
                ctrl.alu_src_a     = 1'b1;
                ctrl.alu_src_b     = 2'd0;
                ctrl.alu_op        = 2'd1;
                ctrl.pc_write_cond = 1'b1;
                ctrl.pc_src        = PCS_ALUOUT;
            end
            ST_JUMP: begin
                ctrl.pc_write = 1'b1;
                ctrl.pc_src   = PCS_JUMP;
            end
            ST_SAVE: begin
                ctrl.epc_write = 1'b1;
            end
            ST_VECTOR: begin
                ctrl.pc_write = 1'b1;
                ctrl.pc_src   = PCS_VECTOR;
            end
            ST_RESUME: begin
                ctrl.pc_write = 1'b1;
                ctrl.pc_src   = PCS_EPC;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
#(
    parameter int CAUSE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               ovf,
    output logic [ST_W-1:0]    state,
    output logic [CAUSE_W-1:0] cause,
    output logic               pc_write,
    output logic               pc_write_cond,
    output logic [2:0]         pc_src,
    output logic               iord,
    output logic               mem_read,
    output logic               mem_write,
    output logic               ir_write,
    output logic               mem_to_reg,
    output logic               reg_dst,
    output logic               reg_write,
    output logic               alu_src_a,
    output logic [1:0]         alu_src_b,
    output logic [1:0]         alu_op,
    output logic               epc_write
);

    localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = CAUSE_W'(0);
    localparam logic [CAUSE_W-1:0] CAUSE_OVF   = CAUSE_W'(1);

    typedef struct packed {
        state_e             state;
        logic [CAUSE_W-1:0] cause;
    } seq_t;

    seq_t     seq_d, seq_q;
    opclass_e op_class;
    logic     is_store;
    ctrl_t    dec;
    logic     ovf_trap;

    mcyc_opclass i_opclass (
        .opcode   (opcode),
        .op_class (op_class),
        .is_store (is_store)
    );

    mcyc_strobe_dec i_strobe_dec (
        .state (seq_q.state),
        .ctrl  (dec)
    );

    assign ovf_trap = (seq_q.state == ST_ALUWB) && ovf;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_FETCH:  seq_d.state = ST_DECODE;
            ST_DECODE: begin
                case (op_class)
                    CL_MEM:    seq_d.state = ST_ADDR;
                    CL_ALU:    seq_d.state = ST_EXEC;
                    CL_BRANCH: seq_d.state = ST_BRANCH;
                    CL_JUMP:   seq_d.state = ST_JUMP;
                    CL_RETURN: seq_d.state = ST_RESUME;
                    default: begin
                        seq_d.state = ST_SAVE;
                        seq_d.cause = CAUSE_UNDEF;
                    end
                endcase
            end
            ST_ADDR:   seq_d.state = is_store ? ST_STORE : ST_LOAD;
            ST_LOAD:   seq_d.state = ST_LDWB;
            ST_EXEC:   seq_d.state = ST_ALUWB;
            ST_ALUWB: begin
                if (ovf) begin
                    seq_d.state = ST_SAVE;
                    seq_d.cause = CAUSE_OVF;
                end else begin
                    seq_d.state = ST_FETCH;
                end
            end
            ST_SAVE:   seq_d.state = ST_VECTOR;
            default:   seq_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_FETCH;
            seq_q.cause <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state         = seq_q.state;
    assign cause         = seq_q.cause;
    assign pc_write      = dec.pc_write;
    assign pc_write_cond = dec.pc_write_cond;
    assign pc_src        = dec.pc_src;
    assign iord          = dec.iord;
    assign mem_read      = dec.mem_read;
    assign mem_write     = dec.mem_write;
    assign ir_write      = dec.ir_write;
    assign mem_to_reg    = dec.mem_to_reg;
    assign reg_dst       = dec.reg_dst;
    assign reg_write     = dec.reg_write & ~ovf_trap;
    assign alu_src_a     = dec.alu_src_a;
    assign alu_src_b     = dec.alu_src_b;
    assign alu_op        = dec.alu_op;
    assign epc_write     = dec.epc_write;

    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    assert_load_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && opcode == OPC_LW) |=> (state == ST_ADDR));

    assert_pcwrite_states_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_write |-> (state == ST_FETCH || state == ST_JUMP ||
                      state == ST_VECTOR || state == ST_RESUME));

    assert_mem_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read && mem_write));

    assert_save_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAVE) |=> (state == ST_VECTOR));

    assert_ovf_divert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALUWB && ovf) |=> (state == ST_SAVE && cause == CAUSE_OVF));

    assert_epc_in_save_R10: assert property (@(posedge clk) disable iff (!rst_n)
        epc_write |-> (state == ST_SAVE));

    assert_cause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_d.state != ST_SAVE) |=> $stable(cause));

endmodule

// File: tb/test_mcyc_ctrl.sv
module test_mcyc_ctrl;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic       ovf;
    logic [3:0] state;
    logic [1:0] cause;
    logic       pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write;
    logic       mem_to_reg, reg_dst, reg_write, alu_src_a, epc_write;
    logic [2:0] pc_src;
    logic [1:0] alu_src_b, alu_op;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mcyc_ctrl i_mcyc_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .ovf(ovf),
        .state(state), .cause(cause), .pc_write(pc_write),
        .pc_write_cond(pc_write_cond), .pc_src(pc_src), .iord(iord),
        .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
        .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .reg_write(reg_write),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .epc_write(epc_write)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (state %0d)", req, act, exp, state);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Expected strobes per state, taken from R2, R6, R7, R10 (ovf assumed ignored or low)
    task automatic expect_strobes(input logic [3:0] s);
        check("R6 pc_write", pc_write,
              (s == 0 || s == 9 || s == 11 || s == 12));
        check("R7 mem_read", mem_read, (s == 0 || s == 3));
        check("R7 mem_write", mem_write, (s == 5));
        check("R10 epc_write", epc_write, (s == 10));
        if (s == 0) check("R2 ir_write", ir_write, 1);
        if (s == 0 || s == 1) check("R6 alu_src_a low", alu_src_a, 0);
        if (s == 2 || s == 6 || s == 8) check("R6 alu_src_a high", alu_src_a, 1);
        if (s == 3 || s == 5) check("R7 iord", iord, 1);
        if (s == 9)  check("R10 pc_src jump", pc_src, 2);
        if (s == 11) check("R10 pc_src vector", pc_src, 3);
        if (s == 12) check("R10 pc_src saved", pc_src, 4);
        if (s == 4 || s == 7) check("R5 reg_write", reg_write, 1);
    endtask

    // From state 0, apply an opcode and follow n states; nibble i of seq is the i-th state
    task automatic run_seq(input logic [5:0] op, input int n, input logic [19:0] seq,
                           input string req);
        opcode = op;
        for (int i = 0; i < n; i++) begin
            step();
            check(req, state, seq[i*4 +: 4]);
            expect_strobes(state);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; opcode = 6'd0; ovf = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state", state, 0);
        check("R1 reset cause", cause, 0);
        expect_strobes(state);
        rst_n = 1'b1;
    endtask

    task automatic t_dispatch();
        run_seq(6'b100011, 5, {4'h0, 4'h4, 4'h3, 4'h2, 4'h1}, "R4 R5 load path");
        run_seq(6'b101011, 4, {4'h0, 4'h0, 4'h5, 4'h2, 4'h1}, "R4 R5 store path");
        run_seq(6'b000000, 4, {4'h0, 4'h0, 4'h7, 4'h6, 4'h1}, "R3 R5 register type");
        run_seq(6'b001111, 4, {4'h0, 4'h0, 4'h7, 4'h6, 4'h1}, "R3 upper immediate");
        run_seq(6'b000100, 3, {4'h0, 4'h0, 4'h0, 4'h8, 4'h1}, "R3 R5 branch equal");
        run_seq(6'b000101, 3, {4'h0, 4'h0, 4'h0, 4'h8, 4'h1}, "R3 branch not equal");
        run_seq(6'b000010, 3, {4'h0, 4'h0, 4'h0, 4'h9, 4'h1}, "R3 R5 jump");
        run_seq(6'b000011, 3, {4'h0, 4'h0, 4'h0, 4'h9, 4'h1}, "R3 jump and link");
        run_seq(6'b010000, 3, {4'h0, 4'h0, 4'h0, 4'hC, 4'h1}, "R3 R10 return");
    endtask

    task automatic t_overflow();
        opcode = 6'b000000;
        step(); check("R9 decode", state, 1);
        step(); check("R9 execute", state, 6);
        step(); check("R9 writeback", state, 7);
        ovf = 1'b1;
        #1;
        check("R9 reg_write blocked", reg_write, 0);
        step();
        check("R9 diverted", state, 10);
        check("R9 cause overflow", cause, 1);
        ovf = 1'b0;
        check("R10 epc_write", epc_write, 1);
        step();
        check("R9 vector", state, 11);
        check("R10 pc_src vector", pc_src, 3);
        step();
        check("R9 back to fetch", state, 0);
        check("R11 cause held", cause, 1);
    endtask

    task automatic t_ovf_ignored();
        ovf = 1'b1;
        run_seq(6'b100011, 5, {4'h0, 4'h4, 4'h3, 4'h2, 4'h1}, "R9 ovf ignored in load");
        ovf = 1'b0;
        check("R11 cause held over load", cause, 1);
    endtask

    task automatic t_undefined();
        run_seq(6'b111111, 4, {4'h0, 4'h0, 4'hB, 4'hA, 4'h1}, "R8 undefined path");
        check("R8 cause undefined", cause, 0);
        run_seq(6'b110000, 2, {4'h0, 4'h0, 4'h0, 4'hA, 4'h1}, "R8 second undefined");
        check("R8 cause undefined again", cause, 0);
        step(); check("R8 vector", state, 11);
        step(); check("R8 fetch", state, 0);
    endtask

    task automatic t_mid_reset();
        opcode = 6'b100011;
        step(); step();
        check("R4 address state", state, 2);
        rst_n = 1'b0;
        #1;
        check("R1 async reset state", state, 0);
        check("R1 async reset cause", cause, 0);
        step();
        rst_n = 1'b1;
        step();
        check("R2 after reset", state, 1);
    endtask

    initial begin
        t_reset();
        t_dispatch();
        t_overflow();
        t_ovf_ignored();
        t_undefined();
        t_mid_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule